// File: doc/BRIEF.md
# Flash Write-Status Top-Bit Generator

This block sits on the read path of a parallel NOR flash and decides what a read returns on the most significant data bit while a program or erase runs in the background. An external command decoder signals the end of a program or erase command sequence with a one-cycle start pulse. That pulse stands for the rising edge of the final write-enable pulse. It arrives together with the operation type, the target address, the value of bit 7 to be programmed, and the mask of sectors chosen for erase. A stub algorithm timer reports completion with a one-cycle done pulse. The storage array sits outside the block, and its read data enters as a plain input.

During a program, a read at the program address returns the complement of the bit being written on bit 7. During an erase, a read in a sector being erased returns 0 on bit 7, and it returns 1 while the erase is suspended. A program to a protected sector, or an erase whose selected sectors are all protected, shows status only for a fixed window. That window is counted in clock cycles from a clock-frequency parameter. After it, the block goes back to plain array reads. Bits 6 to 0 always come from the array.

Top module: `flash_dq7_status`

## Requirements
- R1: After reset, and whenever no operation is running, rd_data equals array_data on all 8 bits.
- R2: From the cycle after an accepted program start until done, a read at the latched program address returns bit 7 equal to the inverse of cmd_d7, with bits 6..0 taken from array_data.
- R3: A done pulse during a program returns the block to array reads from the next cycle, so the true programmed bit is read from the array.
- R4: During an erase that is not suspended, a read whose sector (the top SECT_W address bits) is selected and not protected returns bit 7 = 0. When every sector is selected, this covers any unprotected address.
- R5: While erase_susp is high during an erase, bit 7 reads 1 at the valid erase addresses, and done pulses are ignored.
- R6: While an erase is suspended, a program start to an unprotected sector uses the R2 rule. Its done pulse returns the block to the suspended erase. A program start to a protected sector during suspend is ignored.
- R7: A program start whose address lies in a protected sector shows the R2 status for exactly CLK_MHZ cycles (1 µs) and then returns to array reads. Done pulses in that window are ignored.
- R8: An erase start whose selected sectors are all protected shows bit 7 = 0 at selected-sector addresses for exactly 100*CLK_MHZ cycles and then returns to array reads.
- R9: When only some selected sectors are protected, the erase goes on. Addresses in the protected selected sectors read plain array data.
- R10: While busy, a read at an address that is not valid for status returns array_data on all bits.
- R11: A start pulse during a running program, an abort window, or an unsuspended erase is ignored, and the latched operation stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | One-cycle pulse: command sequence complete |
| cmd_erase | input | 1 | 1 = erase, 0 = program |
| cmd_addr | input | ADDR_W | Program address |
| cmd_d7 | input | 1 | Bit 7 of the datum being programmed |
| sel_mask | input | NSECT | Sectors chosen for erase |
| prot_mask | input | NSECT | Per-sector protection flags |
| erase_susp | input | 1 | Erase suspended |
| alg_done | input | 1 | One-cycle completion pulse from the algorithm timer |
| rd_addr | input | ADDR_W | Read address |
| array_data | input | 8 | Array read data |
| rd_data | output | 8 | Read data with bit 7 replaced by status |

## Verification
A wrong operation state shows up on rd_data[7] at the very next read of a status-valid address. A phase stuck in program or erase keeps the complement or the 0 after done. A dropped suspend shows 0 where 1 is due. A wrong latched address or sector mask moves the status to the wrong locations, while bits 6..0 stay correct. An off-by-one in the abort window appears at its exact last or first cycle, so the bench reads at both edges of each window.

// File: rtl/flash_dq7_pkg.sv
// Shared types for the write-status generator.
package flash_dq7_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_SPROG,
        ST_ABT_P,
        ST_ABT_E
    } op_state_e;
endpackage

// File: rtl/dq7_sector_dec.sv
// Sector decoder: turns an address into a one-hot sector vector.
// Assumes uniform sectors selected by the top SECT_W address bits.
module dq7_sector_dec #(
    parameter int ADDR_W = 12,
    parameter int SECT_W = 3,
    localparam int NSECT = 1 << SECT_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NSECT-1:0]  hit
);
    // One comparator per sector.
    for (genvar i = 0; i < NSECT; i++) begin : g_sect
        assign hit[i] = (addr[ADDR_W-1 -: SECT_W] == SECT_W'(i));
    end
endmodule

// File: rtl/dq7_abort_timer.sv
// Down-counter for the protected-target status windows.
// Assumes the controller leaves its abort state when expired is seen.
module dq7_abort_timer #(
    parameter int PROG_CYC  = 10,
    parameter int ERASE_CYC = 1000,
    localparam int CW = $clog2(ERASE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_p,
    input  logic load_e,
    output logic expired
);
    logic [CW-1:0] cnt_q;

    // Load the window length minus one, then count to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load_p)         cnt_q <= CW'(PROG_CYC - 1);
        else if (load_e)         cnt_q <= CW'(ERASE_CYC - 1);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/dq7_op_ctrl.sv
// Operation controller: tracks which background operation runs
// and latches its target. Assumes cmd_start and alg_done are
// single-cycle pulses and that PROG_CYC is at least 2.
module dq7_op_ctrl
    import flash_dq7_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int SECT_W    = 3,
    parameter int PROG_CYC  = 10,
    parameter int ERASE_CYC = 1000,
    localparam int NSECT = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_erase,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_d7,
    input  logic [NSECT-1:0]  sel_mask,
    input  logic [NSECT-1:0]  prot_mask,
    input  logic              erase_susp,
    input  logic              alg_done,
    output op_state_e         state_q,
    output logic [ADDR_W-1:0] prog_addr_q,
    output logic              prog_d7_q,
    output logic [NSECT-1:0]  erase_mask_q
);
    op_state_e        state_d;
    logic [NSECT-1:0] cmd_sect;
    logic [NSECT-1:0] eff_mask;
    logic             prot_hit;
    logic             load_p, load_e, take_prog, take_erase;
    logic             tmr_zero;

    dq7_sector_dec #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_cmd_dec (
        .addr (cmd_addr),
        .hit  (cmd_sect)
    );

    dq7_abort_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_p  (load_p),
        .load_e  (load_e),
        .expired (tmr_zero)
    );

    assign prot_hit = |(cmd_sect & prot_mask);
    assign eff_mask = sel_mask & ~prot_mask;

    // Next-state selection and latch enables.
    always_comb begin
        state_d    = state_q;
        load_p     = 1'b0;
        load_e     = 1'b0;
        take_prog  = 1'b0;
        take_erase = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_start && !cmd_erase) begin
                    take_prog = 1'b1;
                    if (prot_hit) begin
                        state_d = ST_ABT_P;
                        load_p  = 1'b1;
                    end else begin
                        state_d = ST_PROG;
                    end
                end else if (cmd_start && cmd_erase) begin
                    take_erase = 1'b1;
                    if (eff_mask == '0) begin
                        state_d = ST_ABT_E;
                        load_e  = 1'b1;
                    end else begin
                        state_d = ST_ERASE;
                    end
                end
            end
            ST_PROG:  if (alg_done) state_d = ST_IDLE;
            ST_ERASE: begin
                if (erase_susp) begin
                    if (cmd_start && !cmd_erase && !prot_hit) begin
                        take_prog = 1'b1;
                        state_d   = ST_SPROG;
                    end
                end else if (alg_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_SPROG: if (alg_done) state_d = ST_ERASE;
            ST_ABT_P, ST_ABT_E: if (tmr_zero) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Latch the program target when a program is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_addr_q <= '0;
            prog_d7_q   <= 1'b0;
        end else if (take_prog) begin
            prog_addr_q <= cmd_addr;
            prog_d7_q   <= cmd_d7;
        end
    end

    // Latch the sectors that carry erase status.
    always_ff @(posedge clk) begin
        if (!rst_n)          erase_mask_q <= '0;
        else if (take_erase) erase_mask_q <= (eff_mask == '0) ? sel_mask : eff_mask;
    end

    p_prog_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && alg_done) |=> state_q == ST_IDLE);

    p_susp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE && erase_susp && !cmd_start) |=> state_q == ST_ERASE);

    p_susp_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPROG && alg_done) |=> state_q == ST_ERASE);

    p_abort_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ABT_P || state_q == ST_ABT_E) && !tmr_zero)
        |=> state_q == $past(state_q));

    p_abort_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ABT_P || state_q == ST_ABT_E) && tmr_zero)
        |=> state_q == ST_IDLE);

    p_busy_latch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG || state_q == ST_SPROG || state_q == ST_ABT_P)
        |=> $stable(prog_addr_q) && $stable(prog_d7_q));
endmodule

// File: rtl/flash_dq7_status.sv
// Top: replaces read-data bit 7 with write-operation status.
// Assumes array_data is the array read for rd_addr; bits 6..0 pass.
module flash_dq7_status
    import flash_dq7_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int SECT_W  = 3,
    parameter int CLK_MHZ = 10,
    localparam int NSECT     = 1 << SECT_W,
    localparam int PROG_CYC  = CLK_MHZ,
    localparam int ERASE_CYC = CLK_MHZ * 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_erase,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_d7,
    input  logic [NSECT-1:0]  sel_mask,
    input  logic [NSECT-1:0]  prot_mask,
    input  logic              erase_susp,
    input  logic              alg_done,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        array_data,
    output logic [7:0]        rd_data
);
    op_state_e        state_q;
    logic [ADDR_W-1:0] prog_addr_q;
    logic              prog_d7_q;
    logic [NSECT-1:0]  erase_mask_q;
    logic [NSECT-1:0]  rd_sect;
    logic              prog_hit, erase_hit, dq7;

    dq7_op_ctrl #(
        .ADDR_W(ADDR_W), .SECT_W(SECT_W),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_start    (cmd_start),
        .cmd_erase    (cmd_erase),
        .cmd_addr     (cmd_addr),
        .cmd_d7       (cmd_d7),
        .sel_mask     (sel_mask),
        .prot_mask    (prot_mask),
        .erase_susp   (erase_susp),
        .alg_done     (alg_done),
        .state_q      (state_q),
        .prog_addr_q  (prog_addr_q),
        .prog_d7_q    (prog_d7_q),
        .erase_mask_q (erase_mask_q)
    );

    dq7_sector_dec #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_rd_dec (
        .addr (rd_addr),
        .hit  (rd_sect)
    );

    assign prog_hit  = (rd_addr == prog_addr_q);
    assign erase_hit = |(rd_sect & erase_mask_q);

    // Choose the bit-7 source for the current operation and address.
    always_comb begin
        unique case (state_q)
            ST_PROG, ST_SPROG, ST_ABT_P: dq7 = prog_hit  ? ~prog_d7_q : array_data[7];
            ST_ERASE:                    dq7 = erase_hit ? erase_susp : array_data[7];
            ST_ABT_E:                    dq7 = erase_hit ? 1'b0       : array_data[7];
            default:                     dq7 = array_data[7];
        endcase
    end

    assign rd_data = {dq7, array_data[6:0]};

    p_low_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[6:0] == array_data[6:0]);
endmodule

// File: tb/flash_dq7_status_tb.sv
module flash_dq7_status_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_MHZ    = 10;
    localparam int P_WIN      = CLK_MHZ;
    localparam int E_WIN      = CLK_MHZ * 100;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_start, cmd_erase, cmd_d7, erase_susp, alg_done;
    logic [11:0] cmd_addr, rd_addr;
    logic [7:0]  sel_mask, prot_mask, array_data, rd_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_dq7_status #(.ADDR_W(12), .SECT_W(3), .CLK_MHZ(CLK_MHZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_erase(cmd_erase),
        .cmd_addr(cmd_addr), .cmd_d7(cmd_d7), .sel_mask(sel_mask),
        .prot_mask(prot_mask), .erase_susp(erase_susp), .alg_done(alg_done),
        .rd_addr(rd_addr), .array_data(array_data), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [11:0] a, input logic [7:0] arr,
                       input logic [7:0] exp);
        rd_addr    = a;
        array_data = arr;
        #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rd_data, exp);
        end
    endtask

    task automatic start(input logic er, input logic [11:0] a, input logic d7,
                         input logic [7:0] sel);
        cmd_erase = er; cmd_addr = a; cmd_d7 = d7; sel_mask = sel;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic done_pulse();
        alg_done = 1'b1;
        @(negedge clk);
        alg_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", 12'h123, 8'hA5, 8'hA5);
        chk("R1", 12'hE00, 8'h3C, 8'h3C);
    endtask

    task automatic t_program();
        prot_mask = 8'h00;
        start(1'b0, 12'h123, 1'b1, 8'h00);
        chk("R2", 12'h123, 8'hA5, 8'h25);
        chk("R10", 12'h124, 8'hA5, 8'hA5);
        start(1'b1, 12'h000, 1'b0, 8'hFF);
        chk("R11", 12'h123, 8'hA5, 8'h25);
        chk("R11", 12'h400, 8'hFF, 8'hFF);
        done_pulse();
        chk("R3", 12'h123, 8'hA5, 8'hA5);
        start(1'b0, 12'h0F0, 1'b0, 8'h00);
        chk("R2", 12'h0F0, 8'h5A, 8'hDA);
        done_pulse();
        chk("R3", 12'h0F0, 8'h5A, 8'h5A);
    endtask

    task automatic t_erase();
        prot_mask = 8'b0000_0100;
        start(1'b1, 12'h000, 1'b0, 8'b0000_0110);
        chk("R4", 12'h200, 8'hFF, 8'h7F);
        chk("R9", 12'h400, 8'hFF, 8'hFF);
        chk("R10", 12'h000, 8'hFF, 8'hFF);
        start(1'b0, 12'h200, 1'b1, 8'h00);
        chk("R11", 12'h200, 8'hFF, 8'h7F);
        done_pulse();
        chk("R4", 12'h200, 8'hFF, 8'hFF);
        prot_mask = 8'b0000_0001;
        start(1'b1, 12'h000, 1'b0, 8'hFF);
        chk("R4", 12'hA00, 8'h80, 8'h00);
        chk("R9", 12'h010, 8'h80, 8'h80);
        done_pulse();
    endtask

    task automatic t_suspend();
        prot_mask = 8'b0000_0010;
        start(1'b1, 12'h000, 1'b0, 8'b1000_0000);
        erase_susp = 1'b1;
        chk("R5", 12'hE00, 8'h00, 8'h80);
        done_pulse();
        chk("R5", 12'hE00, 8'h00, 8'h80);
        start(1'b0, 12'h200, 1'b1, 8'h00);
        chk("R6", 12'h200, 8'hFF, 8'hFF);
        chk("R6", 12'hE00, 8'h00, 8'h80);
        start(1'b0, 12'h010, 1'b1, 8'h00);
        chk("R6", 12'h010, 8'h81, 8'h01);
        done_pulse();
        chk("R6", 12'hE00, 8'h00, 8'h80);
        chk("R6", 12'h010, 8'h81, 8'h81);
        erase_susp = 1'b0;
        chk("R4", 12'hE00, 8'h80, 8'h00);
        done_pulse();
        chk("R1", 12'hE00, 8'h80, 8'h80);
    endtask

    task automatic t_prog_abort();
        prot_mask = 8'b0000_1000;
        start(1'b0, 12'h600, 1'b1, 8'h00);
        chk("R7", 12'h600, 8'hFF, 8'h7F);
        done_pulse();
        chk("R7", 12'h600, 8'hFF, 8'h7F);
        repeat (P_WIN - 2) @(negedge clk);
        chk("R7", 12'h600, 8'hFF, 8'h7F);
        @(negedge clk);
        chk("R7", 12'h600, 8'hFF, 8'hFF);
    endtask

    task automatic t_erase_abort();
        prot_mask = 8'b0011_0000;
        start(1'b1, 12'h000, 1'b0, 8'b0011_0000);
        chk("R8", 12'h800, 8'hFF, 8'h7F);
        chk("R10", 12'h000, 8'hFF, 8'hFF);
        repeat (E_WIN - 1) @(negedge clk);
        chk("R8", 12'hA00, 8'hFF, 8'h7F);
        @(negedge clk);
        chk("R8", 12'h800, 8'hFF, 8'hFF);
    endtask

    initial begin
        rst_n = 1'b0; cmd_start = 1'b0; cmd_erase = 1'b0; cmd_d7 = 1'b0;
        erase_susp = 1'b0; alg_done = 1'b0; cmd_addr = '0; rd_addr = '0;
        sel_mask = '0; prot_mask = '0; array_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_erase();
        t_suspend();
        t_prog_abort();
        t_erase_abort();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule